// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general register file of a 32-bit processor core that runs in several privilege modes. A 5-bit mode code supplied by the core decides which physical storage word each architectural index r0–r14 reaches. Some indices are private copies that belong to one mode. Others are storage shared across modes. Index r15 is not stored: it returns a program-counter value that the core supplies. Alongside the general registers, each exception mode owns a 32-bit saved-status word. That word is reachable only while the core runs in the mode that owns it.

The file has two read ports, one write port and one saved-status port. All read data is registered. The index presented before a clock edge yields its data after that edge, and that data is the content as it stood before any write made at the same edge. A mode code outside the seven defined ones raises a sticky fault flag. From then on the file accepts no writes and returns zeros on every read port until the next synchronous reset.

Top module: `banked_regfile`

## Requirements
- R1: The legal mode codes are User 10000, Fast-interrupt 10001, Interrupt 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111. While only legal codes are presented, `mode_fault` stays 0.
- R2: A mode code outside the R1 list, presented while reset is low, sets `mode_fault` at the next clock edge. The flag then stays 1 whatever mode follows, until reset. While reset is high the mode input is ignored and the flag is 0.
- R3: Read data is registered. The index applied before edge N gives its data after edge N. A write to the same register at edge N is not visible until the read that follows edge N.
- R4: Indices r0–r7 reach the same storage in every legal mode.
- R5: In Fast-interrupt mode, indices r8–r14 reach seven words that no other mode can reach.
- R6: Interrupt, Supervisor, Abort and Undefined each own a private pair of words for r13 and r14. In those modes, r8–r12 reach the User storage.
- R7: User and System modes reach identical storage for all of r0–r14.
- R8: Reading index 15 returns `pc_in` as sampled at the read edge. A write to index 15 changes no stored register.
- R9: Each of the five exception modes owns a separate saved-status word. That word is written through `sts_wr_en` and read on `sts_rd_data` (registered) only while the core is in that mode.
- R10: In User or System mode, `sts_rd_data` reads 0 and a saved-status write changes no saved-status word.
- R11: While `mode_fault` is 1, or the current mode code is illegal, every read port returns 0 and all writes are blocked.
- R12: Synchronous reset clears every general register, every saved-status word, the read outputs and the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_in | input | 5 | Current processor mode code |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_b_idx | input | 4 | Read port B architectural index |
| wr_idx | input | 4 | Write port architectural index |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write enable for the general registers |
| pc_in | input | 32 | Program-counter value returned for index 15 |
| sts_wr_en | input | 1 | Saved-status write enable |
| sts_wr_data | input | 32 | Saved-status write data |
| rd_a_data | output | 32 | Registered read data, port A |
| rd_b_data | output | 32 | Registered read data, port B |
| sts_rd_data | output | 32 | Registered saved-status word of the current mode |
| mode_fault | output | 1 | Sticky illegal-mode flag |

## Verification
The assertions take reset to be high on the first clock edge. They also take a single mode code to apply to both the reads and the writes of a cycle, because the block has no separate per-port mode. The stimulus raises reset from time zero and changes every input only on the falling edge. It sweeps all seven legal codes across every index for both read ports, the write port and the saved-status port. An illegal code is presented only once, near the end. A reset then follows, so the bank checks are never masked by the sticky flag.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

  typedef enum logic [4:0] {
    MD_USR = 5'b10000,
    MD_FIQ = 5'b10001,
    MD_IRQ = 5'b10010,
    MD_SVC = 5'b10011,
    MD_ABT = 5'b10111,
    MD_UND = 5'b11011,
    MD_SYS = 5'b11111
  } mode_e;

  // Storage bank selected by the mode; the order past BK_IRQ sets the
  // position of each exception mode's r13/r14 pair and status slot.
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import rbank_pkg::*;
(
  input  logic [4:0] mode,
  output bank_e      bank,
  output logic       legal
);

  always_comb begin
    legal = 1'b1;
    bank  = BK_USR;
    case (mode)
      MD_USR, MD_SYS: bank = BK_USR;
      MD_FIQ:         bank = BK_FIQ;
      MD_IRQ:         bank = BK_IRQ;
      MD_SVC:         bank = BK_SVC;
      MD_ABT:         bank = BK_ABT;
      MD_UND:         bank = BK_UND;
      default:        legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/bank_router.sv
module bank_router
  import rbank_pkg::*;
#(
  parameter int IDXW       = 4,
  parameter int PW         = 5,
  parameter int PC_IDX     = 15,
  parameter int FIQ_FIRST  = 8,
  parameter int PAIR_FIRST = 13,
  parameter int FIQ_BASE   = 15,
  parameter int PAIR_BASE  = 22
) (
  input  bank_e            bank,
  input  logic [IDXW-1:0]  idx,
  output logic [PW-1:0]    phys,
  output logic             is_pc
);

  localparam int PAIR_CNT = PC_IDX - PAIR_FIRST;

  int i_val;
  int b_val;
  int slot;

  always_comb begin
    i_val = int'(idx);
    b_val = int'(bank);
    slot  = i_val;
    if (bank == BK_FIQ && i_val >= FIQ_FIRST && i_val < PC_IDX) begin
      slot = FIQ_BASE + (i_val - FIQ_FIRST);
    end else if (b_val >= int'(BK_IRQ) && i_val >= PAIR_FIRST && i_val < PC_IDX) begin
      slot = PAIR_BASE + PAIR_CNT * (b_val - int'(BK_IRQ)) + (i_val - PAIR_FIRST);
    end
    phys  = PW'(slot);
    is_pc = (i_val == PC_IDX);
  end

endmodule

// File: rtl/status_bank.sv
module status_bank
  import rbank_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NEXC = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  bank_e         bank,
  input  logic          blocked,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  localparam int SW = (NEXC > 1) ? $clog2(NEXC) : 1;

  logic [DW-1:0] sts [NEXC];
  logic          owns;
  logic [SW-1:0] slot;

  always_comb begin
    owns = (bank != BK_USR);
    slot = owns ? SW'(int'(bank) - 1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NEXC; k++) sts[k] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && owns && !blocked) sts[slot] <= wr_data;
      rd_data <= (owns && !blocked) ? sts[slot] : '0;
    end
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rbank_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NIDX       = 16,
  parameter int FIQ_FIRST  = 8,
  parameter int PAIR_FIRST = 13,
  parameter int NEXC       = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4:0]              mode_in,
  input  logic [$clog2(NIDX)-1:0] rd_a_idx,
  input  logic [$clog2(NIDX)-1:0] rd_b_idx,
  input  logic [$clog2(NIDX)-1:0] wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic                    wr_en,
  input  logic [DW-1:0]           pc_in,
  input  logic                    sts_wr_en,
  input  logic [DW-1:0]           sts_wr_data,
  output logic [DW-1:0]           rd_a_data,
  output logic [DW-1:0]           rd_b_data,
  output logic [DW-1:0]           sts_rd_data,
  output logic                    mode_fault
);

  localparam int IDXW      = $clog2(NIDX);
  localparam int PC_IDX    = NIDX - 1;
  localparam int NSHARED   = NIDX - 1;
  localparam int FIQ_CNT   = PC_IDX - FIQ_FIRST;
  localparam int PAIR_CNT  = PC_IDX - PAIR_FIRST;
  localparam int FIQ_BASE  = NSHARED;
  localparam int PAIR_BASE = FIQ_BASE + FIQ_CNT;
  localparam int NPHYS     = PAIR_BASE + PAIR_CNT * (NEXC - 1);
  localparam int PW        = $clog2(NPHYS);
  localparam int NRD       = 2;
  localparam int NPORT     = NRD + 1;

  bank_e          cur_bank;
  logic           legal;
  logic           fault_q;
  logic           blocked;
  logic           wr_ok;

  logic [IDXW-1:0] port_idx  [NPORT];
  logic [PW-1:0]   port_phys [NPORT];
  logic            port_pc   [NPORT];

  logic [DW-1:0]   gpr  [NPHYS];
  logic [DW-1:0]   rd_q [NRD];

  mode_decode u_dec (
    .mode  (mode_in),
    .bank  (cur_bank),
    .legal (legal)
  );

  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign port_idx[2] = wr_idx;

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_route
      bank_router #(
        .IDXW       (IDXW),
        .PW         (PW),
        .PC_IDX     (PC_IDX),
        .FIQ_FIRST  (FIQ_FIRST),
        .PAIR_FIRST (PAIR_FIRST),
        .FIQ_BASE   (FIQ_BASE),
        .PAIR_BASE  (PAIR_BASE)
      ) u_rt (
        .bank  (cur_bank),
        .idx   (port_idx[g]),
        .phys  (port_phys[g]),
        .is_pc (port_pc[g])
      );
    end
  endgenerate

  assign blocked = fault_q || !legal;
  assign wr_ok   = wr_en && !blocked && !port_pc[NRD];

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else if (!legal) fault_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPHYS; k++) gpr[k] <= '0;
    end else if (wr_ok) begin
      gpr[port_phys[NRD]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NRD; r++) begin
      if (rst || blocked) rd_q[r] <= '0;
      else if (port_pc[r]) rd_q[r] <= pc_in;
      else rd_q[r] <= gpr[port_phys[r]];
    end
  end

  status_bank #(
    .DW   (DW),
    .NEXC (NEXC)
  ) u_sts (
    .clk     (clk),
    .rst     (rst),
    .bank    (cur_bank),
    .blocked (blocked),
    .wr_en   (sts_wr_en),
    .wr_data (sts_wr_data),
    .rd_data (sts_rd_data)
  );

  assign rd_a_data  = rd_q[0];
  assign rd_b_data  = rd_q[1];
  assign mode_fault = fault_q;

endmodule

// File: rtl/banked_regfile_checker.sv
module banked_regfile_checker #(
  parameter int DW   = 32,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [4:0]      mode_in,
  input logic [IDXW-1:0] rd_a_idx,
  input logic [DW-1:0]   pc_in,
  input logic [DW-1:0]   rd_a_data,
  input logic [DW-1:0]   rd_b_data,
  input logic [DW-1:0]   sts_rd_data,
  input logic            mode_fault
);

  logic mode_ok;
  logic no_status;

  assign mode_ok = (mode_in == 5'b10000) || (mode_in == 5'b10001) ||
                   (mode_in == 5'b10010) || (mode_in == 5'b10011) ||
                   (mode_in == 5'b10111) || (mode_in == 5'b11011) ||
                   (mode_in == 5'b11111);
  assign no_status = (mode_in == 5'b10000) || (mode_in == 5'b11111);

  p_legal_keeps_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_ok && !mode_fault) |=> !mode_fault);

  p_illegal_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
    !mode_ok |=> mode_fault);

  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    mode_fault |=> mode_fault);

  p_pc_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == IDXW'((1 << IDXW) - 1) && mode_ok && !mode_fault)
      |=> rd_a_data == $past(pc_in));

  p_no_status_r10: assert property (@(posedge clk) disable iff (rst)
    no_status |=> sts_rd_data == '0);

  p_fault_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
    mode_fault |=> (rd_a_data == '0 && rd_b_data == '0 && sts_rd_data == '0));

  p_reset_clears_r12: assert property (@(posedge clk)
    rst |=> (!mode_fault && rd_a_data == '0 && rd_b_data == '0 && sts_rd_data == '0));

endmodule

bind banked_regfile banked_regfile_checker #(
  .DW   (DW),
  .IDXW (IDXW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_in     (mode_in),
  .rd_a_idx    (rd_a_idx),
  .pc_in       (pc_in),
  .rd_a_data   (rd_a_data),
  .rd_b_data   (rd_b_data),
  .sts_rd_data (sts_rd_data),
  .mode_fault  (mode_fault)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode_in = 5'b00000;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] wr_data = '0, pc_in = '0, sts_wr_data = '0;
  logic        wr_en = 1'b0, sts_wr_en = 1'b0;
  logic [31:0] rd_a_data, rd_b_data, sts_rd_data;
  logic        mode_fault;

  int checks = 0;
  int fails  = 0;

  logic [4:0]  modes [7] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};
  logic [31:0] model [0:3199];
  logic [31:0] sts_model [0:31];

  always #5 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst(rst), .mode_in(mode_in), .rd_a_idx(rd_a_idx),
    .rd_b_idx(rd_b_idx), .wr_idx(wr_idx), .wr_data(wr_data), .wr_en(wr_en),
    .pc_in(pc_in), .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .sts_rd_data(sts_rd_data),
    .mode_fault(mode_fault)
  );

  // Storage identity of (mode, index): shared words keep the bare index,
  // private words are keyed by their owning mode code.
  function automatic int owner(logic [4:0] m, int i);
    if (i < 8) return i;
    if (m == M_FIQ) return 100 + i;
    if (i >= 13 && (m == M_IRQ || m == M_SVC || m == M_ABT || m == M_UND))
      return int'(m) * 100 + i;
    return i;
  endfunction

  function automatic string tag_of(logic [4:0] m, int i);
    if (i < 8) return "R4";
    if (m == M_FIQ) return "R5";
    if (m == M_USR || m == M_SYS) return "R7";
    return "R6";
  endfunction

  function automatic logic has_sts(logic [4:0] m);
    return !(m == M_USR || m == M_SYS);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 3200; k++) model[k] = '0;
    for (int k = 0; k < 32; k++) sts_model[k] = '0;

    // R2 / R12: illegal code held during reset is ignored, outputs clear
    repeat (3) tick();
    chk("R2 flag during reset", {31'b0, mode_fault}, 32'd0);
    chk("R12 reset read A", rd_a_data, 32'd0);
    rst = 1'b0;
    mode_in = M_SVC;
    tick();
    chk("R1 flag after legal mode", {31'b0, mode_fault}, 32'd0);

    // Fill every index in every legal mode, including discarded r15 writes
    for (int mi = 0; mi < 7; mi++) begin
      for (int i = 0; i < 16; i++) begin
        mode_in = modes[mi];
        wr_idx  = 4'(i);
        wr_data = {3'b0, modes[mi], 8'(i), 16'hC0DE ^ 16'(mi * 16 + i)};
        wr_en   = 1'b1;
        tick();
        if (i != 15) model[owner(modes[mi], i)] = wr_data;
      end
    end
    wr_en = 1'b0;

    // Sweep both read ports over all modes (R4..R7)
    for (int mi = 0; mi < 7; mi++) begin
      for (int i = 0; i < 15; i++) begin
        mode_in  = modes[mi];
        rd_a_idx = 4'(i);
        rd_b_idx = 4'(14 - i);
        tick();
        chk({tag_of(modes[mi], i), " port A bank read"}, rd_a_data,
            model[owner(modes[mi], i)]);
        chk({tag_of(modes[mi], 14 - i), " port B bank read"}, rd_b_data,
            model[owner(modes[mi], 14 - i)]);
      end
    end
    chk("R1 no flag over legal sweep", {31'b0, mode_fault}, 32'd0);

    // R8: index 15 returns pc_in and r15 writes were discarded
    for (int mi = 0; mi < 7; mi++) begin
      mode_in  = modes[mi];
      rd_a_idx = 4'd15;
      rd_b_idx = 4'd15;
      pc_in    = 32'h8000_0000 + 32'(mi * 4);
      tick();
      chk("R8 pc read A", rd_a_data, 32'h8000_0000 + 32'(mi * 4));
      chk("R8 pc read B", rd_b_data, 32'h8000_0000 + 32'(mi * 4));
    end

    // R3: same-edge write and read returns the old content
    mode_in  = M_USR;
    rd_a_idx = 4'd3;
    wr_idx   = 4'd3;
    wr_data  = 32'hDEAD_0003;
    wr_en    = 1'b1;
    tick();
    chk("R3 old value on same edge", rd_a_data, model[3]);
    model[3] = 32'hDEAD_0003;
    wr_en = 1'b0;
    tick();
    chk("R3 new value next read", rd_a_data, 32'hDEAD_0003);

    // R9 / R10: saved-status writes in every mode, then read back
    for (int mi = 0; mi < 7; mi++) begin
      mode_in     = modes[mi];
      sts_wr_data = 32'h5700_0000 | 32'(modes[mi]);
      sts_wr_en   = 1'b1;
      tick();
      if (has_sts(modes[mi])) sts_model[modes[mi]] = sts_wr_data;
    end
    sts_wr_en = 1'b0;
    for (int mi = 6; mi >= 0; mi--) begin
      mode_in = modes[mi];
      tick();
      if (has_sts(modes[mi]))
        chk("R9 saved status per mode", sts_rd_data, sts_model[modes[mi]]);
      else
        chk("R10 no saved status", sts_rd_data, 32'd0);
    end

    // R2 / R11: illegal code sets the sticky flag, reads go to zero
    mode_in = 5'b10100;
    tick();
    chk("R2 flag set by illegal code", {31'b0, mode_fault}, 32'd1);
    mode_in  = M_SVC;
    rd_a_idx = 4'd0;
    rd_b_idx = 4'd15;
    wr_idx   = 4'd0;
    wr_data  = 32'h1234_5678;
    wr_en    = 1'b1;
    tick();
    chk("R11 read A zero in fault", rd_a_data, 32'd0);
    chk("R11 read B zero in fault", rd_b_data, 32'd0);
    chk("R11 status zero in fault", sts_rd_data, 32'd0);
    wr_en = 1'b0;
    repeat (10) tick();
    chk("R2 flag sticky", {31'b0, mode_fault}, 32'd1);

    // R12: reset clears flag and every stored word
    rst = 1'b1;
    tick();
    chk("R12 flag cleared", {31'b0, mode_fault}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 15; i++) begin
      rd_a_idx = 4'(i);
      rd_b_idx = 4'(i);
      mode_in  = (i >= 8) ? M_FIQ : M_SVC;
      tick();
      chk("R12 register cleared", rd_a_data | rd_b_data, 32'd0);
    end
    mode_in = M_IRQ;
    tick();
    chk("R12 status cleared", sts_rd_data, 32'd0);

    finish_run();
  end

endmodule